// File: doc/BRIEF.md
# DRAM Bank Row-Buffer Command Sequencer

This block stands in for a single DRAM bank with one row buffer. A requester hands it one read or write at a time, each carrying a row and a column address. The block compares the row against the row held open in the buffer and sorts the access into one of three kinds. A hit needs only a column command. An access to a bank with no open row needs an activate and then the column command. A conflict with another open row needs a precharge, an activate and the column command.

Each command takes one timing step of `STEP_CYC` clock cycles. The command code is shown for the first cycle of its step. After the last step the block returns a one-cycle response that carries the data word and the access kind. A small behavioural storage array holds the contents, so a read returns whatever was last written to that row and column, whatever path the read takes.

Top module: `dram_bank_seq`

## Requirements
- R1: After reset `req_ready_o` is 1, `cmd_o` is 0 (NOP) and `rsp_valid_o` is 0. No row is open, and every storage word reads as 0.
- R2: A request whose row equals the open row issues only a column command, RD=3 or WR=4. It reports kind 0 (hit), and `rsp_valid_o` rises STEP_CYC cycles after the acceptance edge.
- R3: A request to a bank with no open row issues ACT=2 and then the column command. It reports kind 1 (empty), and the response comes 2*STEP_CYC cycles after acceptance.
- R4: A request to a row other than the open one issues PRE=1, ACT=2 and the column command in that order. It reports kind 2 (conflict), and the response comes 3*STEP_CYC cycles after acceptance.
- R5: Each command code appears on `cmd_o` for exactly the first cycle of its step. `cmd_o` is 0 in every other cycle and never exceeds 4.
- R6: `req_ready_o` is low from the cycle after acceptance until the response cycle. A request held valid during that time is not taken and does not change the storage.
- R7: `rsp_valid_o` is a single-cycle pulse that follows a column command.
- R8: A read returns the data last written to the same (row, column), whether it is a hit, an empty access or a conflict. A write response returns the written word.
- R9: `cmd_row_o` carries the request row while ACT is issued, and `cmd_col_o` carries the request column while RD or WR is issued.
- R10: `rsp_kind_o` is valid with `rsp_valid_o` and equals the number of commands issued for that request minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Bank idle, able to accept a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_row_i | input | ROW_W | Row address |
| req_col_i | input | COL_W | Column address |
| req_wdata_i | input | DATA_W | Write data |
| cmd_o | output | 3 | Command code: 0 NOP, 1 PRE, 2 ACT, 3 RD, 4 WR |
| cmd_row_o | output | ROW_W | Row of the request in progress |
| cmd_col_o | output | COL_W | Column of the request in progress |
| rsp_valid_o | output | 1 | Completion pulse |
| rsp_rdata_o | output | DATA_W | Read data, or the written word for a write |
| rsp_kind_o | output | 2 | Access kind: 0 hit, 1 empty, 2 conflict |

## Verification
The assertions assume that a requester only counts a transfer when valid and ready are both high on the same edge. They also assume that the request fields do not matter outside that edge, because the block latches them at acceptance. The command-order checks assume that no outside agent precharges or activates the bank. The bench keeps to these rules: it drives inputs only on falling edges and waits for ready before it presents a request. It releases or holds valid before the edge that ends a response, so that a held request is never taken early.

// File: rtl/dram_bank_pkg.sv
package dram_bank_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_PRE = 3'd1,
    CMD_ACT = 3'd2,
    CMD_RD  = 3'd3,
    CMD_WR  = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    KIND_HIT      = 2'd0,
    KIND_EMPTY    = 2'd1,
    KIND_CONFLICT = 2'd2
  } kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE,
    ST_ACT,
    ST_COL
  } state_e;
endpackage

// File: rtl/step_timer.sv
module step_timer #(
  parameter int STEP_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic first_o,
  output logic last_o
);
  localparam int CW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
  localparam logic [CW-1:0] TOP = CW'(STEP_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= TOP;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign first_o = (cnt_q == TOP);
  assign last_o  = (cnt_q == '0);
endmodule

// File: rtl/row_tracker.sv
module row_tracker #(
  parameter int ROW_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pre_i,
  input  logic             act_i,
  input  logic [ROW_W-1:0] act_row_i,
  output logic             open_vld_o,
  output logic [ROW_W-1:0] open_row_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_vld_o <= 1'b0;
      open_row_o <= '0;
    end else if (pre_i) begin
      open_vld_o <= 1'b0;
    end else if (act_i) begin
      open_vld_o <= 1'b1;
      open_row_o <= act_row_i;
    end
  end
endmodule

// File: rtl/bank_store.sv
module bank_store #(
  parameter int ROW_W  = 3,
  parameter int COL_W  = 3,
  parameter int DATA_W = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [ROW_W+COL_W-1:0] addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic [DATA_W-1:0]      rdata_o
);
  localparam int DEPTH = 1 << (ROW_W + COL_W);

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/dram_bank_seq.sv
module dram_bank_seq
  import dram_bank_pkg::*;
#(
  parameter int ROW_W    = 3,
  parameter int COL_W    = 3,
  parameter int DATA_W   = 16,
  parameter int STEP_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic [2:0]        cmd_o,
  output logic [ROW_W-1:0]  cmd_row_o,
  output logic [COL_W-1:0]  cmd_col_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [1:0]        rsp_kind_o
);
  state_e            state_q, state_d;
  logic              we_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, store_rdata;
  kind_e             kind_q, kind_d;
  logic              rsp_valid_q;

  logic accept, busy, t_first, t_last, step_first, step_last;
  logic open_vld;
  logic [ROW_W-1:0] open_row;

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign busy        = !req_ready_o;
  assign step_first  = busy && t_first;
  assign step_last   = busy && t_last;

  step_timer #(.STEP_CYC(STEP_CYC)) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept || (step_last && state_q != ST_COL)),
    .first_o (t_first),
    .last_o  (t_last)
  );

  row_tracker #(.ROW_W(ROW_W)) i_tracker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pre_i      (step_first && state_q == ST_PRE),
    .act_i      (step_first && state_q == ST_ACT),
    .act_row_i  (row_q),
    .open_vld_o (open_vld),
    .open_row_o (open_row)
  );

  bank_store #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) i_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (step_last && state_q == ST_COL && we_q),
    .addr_i  ({row_q, col_q}),
    .wdata_i (wdata_q),
    .rdata_o (store_rdata)
  );

  // classify against the open row at acceptance
  always_comb begin
    if (!open_vld)                  kind_d = KIND_EMPTY;
    else if (open_row == req_row_i) kind_d = KIND_HIT;
    else                            kind_d = KIND_CONFLICT;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        unique case (kind_d)
          KIND_HIT:   state_d = ST_COL;
          KIND_EMPTY: state_d = ST_ACT;
          default:    state_d = ST_PRE;
        endcase
      end
      ST_PRE:  if (step_last) state_d = ST_ACT;
      ST_ACT:  if (step_last) state_d = ST_COL;
      ST_COL:  if (step_last) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      we_q        <= 1'b0;
      row_q       <= '0;
      col_q       <= '0;
      wdata_q     <= '0;
      kind_q      <= KIND_HIT;
      rsp_valid_q <= 1'b0;
      rdata_q     <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= 1'b0;
      if (accept) begin
        we_q    <= req_write_i;
        row_q   <= req_row_i;
        col_q   <= req_col_i;
        wdata_q <= req_wdata_i;
        kind_q  <= kind_d;
      end
      if (step_last && state_q == ST_COL) begin
        rsp_valid_q <= 1'b1;
        rdata_q     <= we_q ? wdata_q : store_rdata;
      end
    end
  end

  always_comb begin
    cmd_o = CMD_NOP;
    if (step_first) begin
      unique case (state_q)
        ST_PRE:  cmd_o = CMD_PRE;
        ST_ACT:  cmd_o = CMD_ACT;
        ST_COL:  cmd_o = we_q ? CMD_WR : CMD_RD;
        default: cmd_o = CMD_NOP;
      endcase
    end
  end

  assign cmd_row_o   = row_q;
  assign cmd_col_o   = col_q;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rdata_q;
  assign rsp_kind_o  = kind_q;
endmodule

// File: rtl/dram_bank_seq_chk.sv
module dram_bank_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic       req_ready_o,
  input logic [2:0] cmd_o,
  input logic       rsp_valid_o,
  input logic [1:0] rsp_kind_o
);
  logic [2:0] last_cmd_q;
  logic [1:0] n_cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_cmd_q <= 3'd0;
      n_cmd_q    <= 2'd0;
    end else begin
      if (cmd_o != 3'd0) last_cmd_q <= cmd_o;
      if (req_valid_i && req_ready_o) n_cmd_q <= 2'd0;
      else if (cmd_o != 3'd0)         n_cmd_q <= n_cmd_q + 2'd1;
    end
  end

  assert_busy_after_accept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  assert_cmd_only_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o != 3'd0) |-> !req_ready_o);

  assert_cmd_legal_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o <= 3'd4);

  assert_act_order_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == 3'd2) |-> (last_cmd_q == 3'd0 || last_cmd_q == 3'd1));

  assert_pre_order_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == 3'd1) |-> (last_cmd_q == 3'd3 || last_cmd_q == 3'd4));

  assert_rsp_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  assert_rsp_after_col_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (last_cmd_q == 3'd3 || last_cmd_q == 3'd4));

  assert_kind_steps_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (n_cmd_q == rsp_kind_o + 2'd1));
endmodule

bind dram_bank_seq dram_bank_seq_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .cmd_o       (cmd_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_kind_o  (rsp_kind_o)
);

// File: tb/test_dram_bank_seq.sv
module test_dram_bank_seq;
  localparam int ROW_W = 3, COL_W = 3, DATA_W = 16, STEP = 2;
  localparam logic [2:0] NOP = 3'd0, PRE = 3'd1, ACT = 3'd2, RD = 3'd3, WR = 3'd4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [2:0] cmd;
  logic [ROW_W-1:0] cmd_row;
  logic [COL_W-1:0] cmd_col;
  logic [DATA_W-1:0] rsp_rdata;
  logic [1:0] rsp_kind;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dram_bank_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .STEP_CYC(STEP)) i_dram_bank_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_row_i(req_row), .req_col_i(req_col), .req_wdata_i(req_wdata),
    .cmd_o(cmd), .cmd_row_o(cmd_row), .cmd_col_o(cmd_col),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .rsp_kind_o(rsp_kind)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // kind: 0 hit, 1 empty, 2 conflict. hold_busy keeps valid high with a stray write while busy.
  task automatic do_req(input bit wr, input int row, input int col, input int wdata,
                        input int kind, input int exp_data, input bit hold_busy);
    int n = kind + 1;
    logic [2:0] seq [3];
    int s = 0;
    bit ready_bad = 1'b0, cmd_bad = 1'b0, addr_bad = 1'b0;
    int j = 0;
    logic [2:0] colcmd = wr ? WR : RD;
    if (kind == 0) seq[0] = colcmd;
    else if (kind == 1) begin seq[0] = ACT; seq[1] = colcmd; end
    else begin seq[0] = PRE; seq[1] = ACT; seq[2] = colcmd; end
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr;
    req_row = ROW_W'(row); req_col = COL_W'(col); req_wdata = DATA_W'(wdata);
    @(posedge clk);
    forever begin
      @(negedge clk);
      j++;
      if (j == 1) begin
        if (hold_busy) begin
          req_write = 1'b1; req_row = ROW_W'(row); req_col = COL_W'(col);
          req_wdata = 16'hDEAD;
        end else req_valid = 1'b0;
      end
      if (rsp_valid || j > 40) break;
      if (req_ready) ready_bad = 1'b1;
      if (s < n && j == s * STEP + 1) begin
        if (cmd !== seq[s]) cmd_bad = 1'b1;
        if (cmd == ACT && cmd_row !== ROW_W'(row)) addr_bad = 1'b1;
        if ((cmd == RD || cmd == WR) && cmd_col !== COL_W'(col)) addr_bad = 1'b1;
        s++;
      end else if (cmd !== NOP) cmd_bad = 1'b1;
    end
    req_valid = 1'b0;
    check(j == n * STEP + 1, (kind == 0) ? "R2 latency" : (kind == 1) ? "R3 latency" : "R4 latency",
          j, n * STEP + 1);
    check(!cmd_bad && s == n, (kind == 0) ? "R2/R5 cmd seq" : (kind == 1) ? "R3/R5 cmd seq" : "R4/R5 cmd seq",
          s, n);
    check(!ready_bad && req_ready, "R6 ready low while busy", ready_bad, 0);
    check(!addr_bad, "R9 cmd address", addr_bad, 0);
    check(rsp_kind == 2'(kind), "R10 kind", rsp_kind, kind);
    check(rsp_rdata == DATA_W'(exp_data), "R8 data", rsp_rdata, exp_data);
    @(negedge clk);
    check(!rsp_valid, "R7 rsp single pulse", rsp_valid, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    check(cmd == NOP, "R1 cmd NOP after reset", cmd, NOP);
    check(rsp_valid == 1'b0, "R1 no rsp after reset", rsp_valid, 0);
  endtask

  task automatic t_empty_write();   // R3: first access hits an empty bank
    do_req(1'b1, 2, 3, 16'hA5A5, 1, 16'hA5A5, 1'b0);
  endtask

  task automatic t_hit_read();      // R2, R8
    do_req(1'b0, 2, 3, 0, 0, 16'hA5A5, 1'b0);
    do_req(1'b1, 2, 5, 16'h1234, 0, 16'h1234, 1'b0);
  endtask

  task automatic t_conflict();      // R4, R1 (unwritten reads 0), R8 across conflict
    do_req(1'b0, 4, 3, 0, 2, 16'h0000, 1'b0);
    do_req(1'b0, 2, 5, 0, 2, 16'h1234, 1'b0);
    do_req(1'b0, 2, 3, 0, 0, 16'hA5A5, 1'b0);
  endtask

  task automatic t_busy_ignore();   // R6: stray write held during busy must not land
    do_req(1'b0, 7, 1, 0, 2, 16'h0000, 1'b1);
    do_req(1'b0, 7, 1, 0, 0, 16'h0000, 1'b0);
  endtask

  task automatic t_back_to_back();  // R8: write then read across rows
    do_req(1'b1, 0, 0, 16'h0F0F, 2, 16'h0F0F, 1'b0);
    do_req(1'b1, 5, 7, 16'hBEEF, 2, 16'hBEEF, 1'b0);
    do_req(1'b0, 0, 0, 0, 2, 16'h0F0F, 1'b0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_empty_write();
    t_hit_read();
    t_conflict();
    t_busy_ignore();
    t_back_to_back();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule